// File: doc/BRIEF.md
# Triple Half-Bridge Switch Controller

This block is the digital core behind three half-bridges. Each bridge has a low-side and a high-side power switch. A 16-bit control word, committed by a one-cycle load strobe, says which switches should conduct. It also sets which of them follow a shared external PWM input, whether overcurrent shutdown is armed, whether the open-load view is active, and whether the outputs run or stay in standby. Analog sense circuits supply per-switch short-circuit, overtemperature and open-load flags, plus a supply-undervoltage flag and a temperature-prewarning flag.

The block drives six registered gate enables. It never lets both switches of one bridge conduct together. When a bridge hands over from one side to the other, it waits a programmable dead time. Faults shut down the affected switch and hold it off. The block also assembles a 16-bit status word with sticky overload and supply-fail latches, which the status-reset bit of a later control word clears.

Top module: `hb_bridge_ctrl`

## Requirements
- R1: On-request bits sit at control bits 1..6 in the order LS1, HS1, LS2, HS2, LS3, HS3 (1 = on) and drive gate_en[0..5] in that order. A word loaded at clock edge E takes effect on gate_en at edge E+1. After reset the control word is all zero.
- R2: Control bits 7..12 are PWM enables in the same switch order. With its enable set, a switch conducts only while both its on-bit and pwm_in are 1. With its enable clear, pwm_in has no effect on it.
- R3: If both switches of one bridge are requested, both are held off. The two switches of a bridge are never on in the same cycle.
- R4: After one side of a bridge turns off, the opposite side turns on no sooner than DEAD_CYC+1 cycles later. The same side may turn back on in the very next cycle.
- R5: A switch that is on trips off on overtemperature, or on short circuit when control bit 14 is 1. With bit 14 at 0, a short circuit is ignored. A tripped switch stays off until a control load has its on-bit at 0 or has bit 0 (status reset) at 1.
- R6: Status bit 13 (overload) sets when any switch trips. It stays set until a control load with bit 0 at 1.
- R7: While uv_flag is 1, all gates are forced off. Gates resume once it clears. Status bit 15 latches any undervoltage and is cleared only by a control load with bit 0 at 1.
- R8: Control bit 15 at 0 (standby, the reset state) forces all gates off and sets status bit 14. The reset status word is 0x4000.
- R9: Status bit 0 mirrors temp_warn. Status bits 7..12 read 0. With control bit 13 at 1, status bits 1..6 show the gate state of LS1..HS3.
- R10: With control bit 13 at 0 (open-load view), status bits 1..6 show open_load of each switch while that switch is off, and 0 while it is on. A status reset leaves this view unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 16 | Control word, sampled when ctrl_load is 1 |
| ctrl_load | input | 1 | One-cycle strobe that commits ctrl_word |
| pwm_in | input | 1 | Shared external PWM signal |
| fault_short | input | 6 | Short-circuit flag per switch (LS1..HS3) |
| fault_temp | input | 6 | Overtemperature flag per switch |
| open_load | input | 6 | Open-load flag per switch |
| uv_flag | input | 1 | Supply undervoltage detected |
| temp_warn | input | 1 | Temperature prewarning |
| gate_en | output | 6 | Gate enables LS1, HS1, LS2, HS2, LS3, HS3 |
| status_word | output | 16 | Assembled status word |

## Verification
The bench builds the block with NUM_LEGS=3 and DEAD_CYC=3, so all six switches and every control and status field are in play. A three-cycle dead time produces a four-cycle gap in a side handover. That gap is clearly longer than the single register stage, so the bench can measure the exact turn-on edge of the opposite side and also confirm that a PWM-gated switch resumes on the same side with no wait.

// File: rtl/hb_pkg.sv
package hb_pkg;
   localparam int MAX_LEGS = 3;
   localparam int MAX_SW   = 2 * MAX_LEGS;
   localparam int WORD_W   = 16;

   typedef struct packed {
      logic              run;      // 1 = outputs active
      logic              ocs_en;   // arm short-circuit shutdown
      logic              norm_n;   // 0 = open-load view
      logic [MAX_SW-1:0] pwm_en;   // per switch PWM gating
      logic [MAX_SW-1:0] on_req;   // per switch on request
      logic              clr;      // status reset
   } ctrl_t;

   typedef struct packed {
      logic              psf;
      logic              stby;
      logic              ovl;
      logic [5:0]        spare;
      logic [MAX_SW-1:0] sw;
      logic              warn;
   } stat_t;
endpackage

// File: rtl/hb_leg.sv
module hb_leg #(
   parameter int DEAD_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwm_in,
   input  logic       run,
   input  logic       ocs_en,
   input  logic [1:0] on_bit,
   input  logic [1:0] pwm_en,
   input  logic       ld,
   input  logic [1:0] ld_on,
   input  logic       ld_clr,
   input  logic [1:0] f_short,
   input  logic [1:0] f_temp,
   output logic [1:0] gate,
   output logic       trip_evt
);
   localparam int CNT_W = $clog2(DEAD_CYC + 1);

   logic [1:0]       gate_q, gate_d, trip_q, trip_set, trip_clr, req, ok, want;
   logic [CNT_W-1:0] cnt_q;
   logic             last_q;   // side that turned off most recently
   logic             fall_any;

   always_comb begin
      req      = on_bit & (~pwm_en | {2{pwm_in}});
      trip_set = gate_q & (f_temp | (f_short & {2{ocs_en}}));
      trip_clr = {2{ld & ld_clr}} | ({2{ld}} & ~ld_on);
      ok       = req & ~trip_q & ~trip_set & {2{run}};
      want     = (ok == 2'b11) ? 2'b00 : ok;
      for (int s = 0; s < 2; s++) begin
         gate_d[s] = want[s] &
                     (gate_q[s] | (!gate_q[1-s] && (cnt_q == '0 || last_q == s[0])));
      end
      fall_any = |(gate_q & ~gate_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= '0;
         trip_q <= '0;
         cnt_q  <= '0;
         last_q <= 1'b0;
      end else begin
         gate_q <= gate_d;
         trip_q <= (trip_q & ~trip_clr) | trip_set;
         if (fall_any) begin
            cnt_q  <= CNT_W'(DEAD_CYC);
            last_q <= gate_q[1];
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign gate     = gate_q;
   assign trip_evt = |trip_set;
endmodule

// File: rtl/hb_status.sv
module hb_status
   import hb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic              ld_clr,
   input  logic              trip_evt,
   input  logic              uv,
   input  logic              run,
   input  logic              norm_n,
   input  logic              warn,
   input  logic [MAX_SW-1:0] open_load,
   input  logic [MAX_SW-1:0] gate,
   output logic [WORD_W-1:0] status
);
   logic  ovl_q, psf_q, wipe;
   stat_t st;

   assign wipe = ld & ld_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovl_q <= 1'b0;
         psf_q <= 1'b0;
      end else begin
         ovl_q <= (ovl_q & ~wipe) | trip_evt;
         psf_q <= (psf_q & ~wipe) | uv;
      end
   end

   always_comb begin
      st.psf   = psf_q;
      st.stby  = ~run;
      st.ovl   = ovl_q;
      st.spare = '0;
      st.sw    = norm_n ? gate : (open_load & ~gate);
      st.warn  = warn;
   end

   assign status = st;
endmodule

// File: rtl/hb_bridge_ctrl.sv
module hb_bridge_ctrl
   import hb_pkg::*;
#(
   parameter int NUM_LEGS = 3,
   parameter int DEAD_CYC = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] ctrl_word,
   input  logic        ctrl_load,
   input  logic        pwm_in,
   input  logic [5:0]  fault_short,
   input  logic [5:0]  fault_temp,
   input  logic [5:0]  open_load,
   input  logic        uv_flag,
   input  logic        temp_warn,
   output logic [5:0]  gate_en,
   output logic [15:0] status_word
);
   if (NUM_LEGS < 1 || NUM_LEGS > MAX_LEGS) begin : g_bad_legs
      $error("NUM_LEGS must lie in 1..3");
   end
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least 1");
   end

   ctrl_t               cfg_q, cfg_in;
   logic                run;
   logic [MAX_LEGS-1:0] trip_leg;
   logic [MAX_SW-1:0]   gates;

   assign cfg_in = ctrl_t'(ctrl_word);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q <= '0;
      else if (ctrl_load) cfg_q <= cfg_in;
   end

   assign run = cfg_q.run & ~uv_flag;

   for (genvar k = 0; k < MAX_LEGS; k++) begin : g_leg
      if (k < NUM_LEGS) begin : g_on
         hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .pwm_in   (pwm_in),
            .run      (run),
            .ocs_en   (cfg_q.ocs_en),
            .on_bit   (cfg_q.on_req[2*k+1:2*k]),
            .pwm_en   (cfg_q.pwm_en[2*k+1:2*k]),
            .ld       (ctrl_load),
            .ld_on    (cfg_in.on_req[2*k+1:2*k]),
            .ld_clr   (cfg_in.clr),
            .f_short  (fault_short[2*k+1:2*k]),
            .f_temp   (fault_temp[2*k+1:2*k]),
            .gate     (gates[2*k+1:2*k]),
            .trip_evt (trip_leg[k])
         );
      end else begin : g_off
         assign gates[2*k+1:2*k] = 2'b00;
         assign trip_leg[k]      = 1'b0;
      end
   end

   hb_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (ctrl_load),
      .ld_clr    (cfg_in.clr),
      .trip_evt  (|trip_leg),
      .uv        (uv_flag),
      .run       (cfg_q.run),
      .norm_n    (cfg_q.norm_n),
      .warn      (temp_warn),
      .open_load (open_load),
      .gate      (gates),
      .status    (status_word)
   );

   assign gate_en = gates;
endmodule

// File: rtl/hb_bridge_chk.sv
module hb_bridge_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] ctrl_word,
   input logic        ctrl_load,
   input logic        uv_flag,
   input logic [5:0]  fault_temp,
   input logic [5:0]  gate_en,
   input logic [15:0] status_word
);
   for (genvar k = 0; k < 3; k++) begin : g_leg
      AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
         !(gate_en[2*k] && gate_en[2*k+1])); // R3
      AST_DEAD_LO_HI: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(gate_en[2*k]) |=> !gate_en[2*k+1]); // R4
      AST_DEAD_HI_LO: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(gate_en[2*k+1]) |=> !gate_en[2*k]); // R4
   end

   AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flag |=> gate_en == 6'b0); // R7
   AST_PSF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[15] && !(ctrl_load && ctrl_word[0]) |=> status_word[15]); // R7
   AST_STBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[14] |=> gate_en == 6'b0); // R8
   AST_OVL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|(fault_temp & gate_en)) |=> status_word[13]); // R6
   AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[12:7] == 6'b0); // R9
endmodule

bind hb_bridge_ctrl hb_bridge_chk u_chk (.*);

// File: tb/sim_hb_bridge_ctrl.sv
module sim_hb_bridge_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ctrl_word = '0;
   logic        ctrl_load = 1'b0;
   logic        pwm_in = 1'b0;
   logic [5:0]  fault_short = '0, fault_temp = '0, open_load = '0;
   logic        uv_flag = 1'b0, temp_warn = 1'b0;
   logic [5:0]  gate_en;
   logic [15:0] status_word;
   int          errors = 0, checks = 0;

   always #5 clk = ~clk;

   hb_bridge_ctrl #(.NUM_LEGS(3), .DEAD_CYC(3)) u0 (.*);

   typedef struct packed {
      logic [15:0] w;
      logic        pwm;
      logic        uv;
      logic [5:0]  g;
      logic [15:0] st;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{16'hA000, 1'b0, 1'b0, 6'h00, 16'h0000},
      '{16'hA032, 1'b0, 1'b0, 6'h19, 16'h0032},
      '{16'hA04C, 1'b0, 1'b0, 6'h26, 16'h004C},
      '{16'hA046, 1'b0, 1'b0, 6'h20, 16'h0040},
      '{16'hA082, 1'b0, 1'b0, 6'h00, 16'h0000},
      '{16'hA082, 1'b1, 1'b0, 6'h01, 16'h0002},
      '{16'h2032, 1'b0, 1'b0, 6'h00, 16'h4000},
      '{16'hA032, 1'b0, 1'b1, 6'h00, 16'h8000}
   };

   function automatic string vtag(int i);
      case (i)
         0, 1:    return "R1 R9";
         2:       return "R4 R1";
         3:       return "R3";
         4, 5:    return "R2";
         6:       return "R8";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load(input logic [15:0] w);
      @(negedge clk);
      ctrl_word = w;
      ctrl_load = 1'b1;
      @(negedge clk);
      ctrl_load = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL R1: watchdog expired, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(2);
      rst_n = 1'b1;
      idle(1);
      chk("R8 reset gates", {10'b0, gate_en}, 16'h0000);
      chk("R8 reset status", status_word, 16'h4000);

      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         pwm_in  = VECS[i].pwm;
         uv_flag = VECS[i].uv;
         load(VECS[i].w);
         idle(7);
         chk({vtag(i), " gates"}, {10'b0, gate_en}, {10'b0, VECS[i].g});
         chk({vtag(i), " status"}, status_word, VECS[i].st);
      end

      // R7: undervoltage released, gates resume, supply-fail stays latched
      uv_flag = 1'b0;
      idle(1);
      chk("R7 gates resume", {10'b0, gate_en}, 16'h0019);
      chk("R7 psf sticky", status_word, 16'h8032);
      load(16'hA033);
      chk("R7 psf cleared", status_word, 16'h0032);

      // R5: short ignored while shutdown disarmed
      fault_short = 6'b000001;
      idle(2);
      chk("R5 short ignored", {10'b0, gate_en}, 16'h0019);
      chk("R5 no overload", status_word, 16'h0032);
      load(16'hE032);
      idle(2);
      chk("R5 short trip", {10'b0, gate_en}, 16'h0018);
      chk("R6 overload set", status_word, 16'h2030);
      fault_short = '0;
      idle(2);
      chk("R5 trip held", {10'b0, gate_en}, 16'h0018);
      load(16'hE032);
      idle(2);
      chk("R5 same word keeps trip", {10'b0, gate_en}, 16'h0018);
      load(16'hE033);
      idle(1);
      chk("R5 reset restores", {10'b0, gate_en}, 16'h0019);
      chk("R6 overload cleared", status_word, 16'h0032);

      // R5 overtemperature trips regardless of shutdown arming
      fault_temp = 6'b001000;
      idle(2);
      chk("R5 temp trip", {10'b0, gate_en}, 16'h0011);
      chk("R6 temp overload", status_word, 16'h2022);
      fault_temp = '0;
      load(16'hA022);
      idle(2);
      chk("R6 overload sticky", status_word, 16'h2022);
      load(16'hA032);
      idle(2);
      chk("R5 cleared by off bit", {10'b0, gate_en}, 16'h0019);
      chk("R6 still set", status_word, 16'h2032);
      load(16'hA033);
      chk("R6 reset", status_word, 16'h0032);

      // R4: dead time on a side handover in bridge 1
      load(16'hA002);
      idle(8);
      chk("R4 start", {10'b0, gate_en}, 16'h0001);
      load(16'hA004);
      idle(1);
      chk("R4 low off", {10'b0, gate_en}, 16'h0000);
      idle(3);
      chk("R4 still dead", {10'b0, gate_en}, 16'h0000);
      idle(1);
      chk("R4 high on", {10'b0, gate_en}, 16'h0002);

      // R2 and R4: same-side PWM gating resumes without dead time
      pwm_in = 1'b1;
      load(16'hA082);
      idle(8);
      chk("R2 pwm high", {10'b0, gate_en}, 16'h0001);
      pwm_in = 1'b0;
      idle(1);
      chk("R2 pwm low", {10'b0, gate_en}, 16'h0000);
      pwm_in = 1'b1;
      idle(1);
      chk("R4 same side resume", {10'b0, gate_en}, 16'h0001);

      // R10 and R9: open-load view, prewarning
      open_load = 6'b000011;
      temp_warn = 1'b1;
      load(16'h8002);
      idle(2);
      chk("R10 open-load view", status_word, 16'h0005);
      chk("R10 gates unchanged", {10'b0, gate_en}, 16'h0001);
      load(16'h8003);
      idle(1);
      chk("R10 reset no effect", status_word, 16'h0005);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule